// File: doc/BRIEF.md
# Two-Thread Physically Tagged Level-One Data Cache

This block is a level-one data cache that two hardware threads share. Each thread presents a virtual address and the physical page number that its translation produced for it. The set is chosen from page-offset bits of the virtual address, which are equal in the virtual and physical address when pages are 4 KiB. The ways of that set are then compared in parallel against the physical tag. Two threads, or two address spaces, that reach one physical line through different virtual addresses therefore meet in the same entry. A matching virtual address that maps to another physical page never gives a hit.

A round-robin arbiter accepts one thread request per cycle. Hits answer one cycle after acceptance. Stores update the cached line and mark it dirty. A miss holds the cache busy while the line moves through a next-level memory port. A dirty victim is first written out as a whole line, then the missing line is read in, and then the access is replayed against it. There is no fixed split of ways between the threads. A victim is the lowest-numbered invalid way if one exists, and otherwise the way chosen by a pseudo-LRU tree kept for each set.

Top module: `vipt_dcache`

## Requirements
- R1: The physical address is the page number placed above virtual bits [11:0]. Bits [5:0] select the byte in a 64-byte line and virtual bits [11:6] select one of 64 sets. The tag is the physical page number, and data words are 32 bits wide, selected by bits [5:2].
- R2: A read hit puts the selected word on rspData and raises rspValid of the requesting thread one cycle after acceptance, with busy staying low.
- R3: Accesses to one physical line through different virtual addresses or threads hit the same entry. An equal virtual address with a different page number misses.
- R4: A write hit replaces the addressed word in the cached line, responds with the written word one cycle later, and makes no memory transfer.
- R5: A miss raises busy in the cycle after acceptance. The cache fetches the line at its line-aligned physical address (low 6 bits zero), replays the access, and then responds with correct data. A write miss stores into the refilled line.
- R6: When the victim is dirty, its full line is written out to its own physical line address, and that writeback completes before the refill request starts. A clean victim causes only a refill.
- R7: A fill uses the lowest-numbered invalid way. In a full set it uses the tree pseudo-LRU victim. If eight lines fill a set in order and the first is touched again, the next miss evicts the fifth.
- R8: At most one thread is granted per cycle. When both threads request, the one not granted last wins, and a thread that keeps requesting after losing is granted in the next free cycle.
- R9: While busy is high no request is granted. The waiting thread is granted in the first cycle after busy falls.
- R10: After reset every line is invalid, and rspValid, busy, memReq and reqGrant are low.
- R11: memReq stays high with memWe and memAddr unchanged until the one-cycle memAck pulse, and memRdata is taken in the cycle of that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 2 | Per-thread request valid |
| reqWrite | input | 2 | Per-thread store (1) or load (0) |
| reqVaddr | input | 2x32 | Per-thread virtual address |
| reqPpn | input | 2x20 | Per-thread physical page number |
| reqWdata | input | 2x32 | Per-thread store data |
| reqGrant | output | 2 | Request accepted this cycle |
| rspValid | output | 2 | Per-thread response strobe |
| rspData | output | 32 | Load data or echoed store data |
| busy | output | 1 | Miss in progress |
| memReq | output | 1 | Next-level transfer request |
| memWe | output | 1 | 1 for writeback, 0 for refill |
| memAddr | output | 32 | Line-aligned physical address |
| memWdata | output | 512 | Writeback line |
| memRdata | input | 512 | Refill line |
| memAck | input | 1 | Transfer done pulse |

## Verification
The bench builds the cache with its default parameters: 64-byte lines, 64 sets, 8 ways and 20-bit page numbers, so the tag is exactly the page number. With these values the top set (index 63) and the last word of a line can be reached. Eight lines fill one set completely, so the pseudo-LRU victim differs from true LRU and a dirty eviction can be forced in a known order. Aliasing between threads is exercised with virtual addresses whose upper bits differ while the page offset is the same.

// File: rtl/vipt_dcache_pkg.sv
package vipt_dcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WBACK,
    ST_REFILL,
    ST_REPLAY
  } cacheState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // lookup from the granted port this cycle
    logic selThr;   // granted thread
    logic replay;   // lookup from the pending miss
    logic fillEn;   // install refill line into the victim way
    logic wbPhase;  // memory address is the victim line
  } dpStrobe_t;

endpackage

// File: rtl/vipt_dcache_ctrl.sv
module vipt_dcache_ctrl
  import vipt_dcache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] reqValid,
  input  logic       lookupHit,
  input  logic       victimDirty,
  input  logic       memAck,
  output logic [1:0] grant,
  output logic       busy,
  output logic       memReq,
  output logic       memWe,
  output dpStrobe_t  strobe
);

  cacheState_t state, stateNext;
  logic lastThr;
  logic pick;
  logic anyReq;
  logic idle;

  assign anyReq = |reqValid;
  assign idle   = (state == ST_IDLE);
  assign pick   = (reqValid == 2'b11) ? ~lastThr : reqValid[1];

  assign grant  = (idle && anyReq) ? (pick ? 2'b10 : 2'b01) : 2'b00;
  assign busy   = !idle;
  assign memReq = (state == ST_WBACK) || (state == ST_REFILL);
  assign memWe  = (state == ST_WBACK);

  always_comb begin
    strobe         = '0;
    strobe.accept  = idle && anyReq;
    strobe.selThr  = pick;
    strobe.replay  = (state == ST_REPLAY);
    strobe.fillEn  = (state == ST_REFILL) && memAck;
    strobe.wbPhase = (state == ST_WBACK);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (anyReq && !lookupHit) stateNext = victimDirty ? ST_WBACK : ST_REFILL;
      ST_WBACK:  if (memAck) stateNext = ST_REFILL;
      ST_REFILL: if (memAck) stateNext = ST_REPLAY;
      ST_REPLAY: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      lastThr <= 1'b1;
    end else begin
      state <= stateNext;
      if (idle && anyReq) lastThr <= pick;
    end
  end

  // R8
  rr_alt0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid == 2'b11 && grant == 2'b01) |=> (reqValid != 2'b11 || busy || grant == 2'b10));
  // R8
  rr_alt1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid == 2'b11 && grant == 2'b10) |=> (reqValid != 2'b11 || busy || grant == 2'b01));
  // R9
  busy_nogrant_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (grant == 2'b00));
  // R5
  miss_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && !lookupHit) |=> busy);
  // R6
  wb_then_refill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck) |=> (memReq && !memWe));
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));

endmodule

// File: rtl/vipt_dcache_dp.sv
module vipt_dcache_dp
  import vipt_dcache_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 64,
  parameter int WAYS       = 8,
  parameter int PPN_W      = 20,
  parameter int PAGE_BITS  = 12,
  parameter int VA_W       = 32,
  parameter int WORD_W     = 32,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int WORDS  = LINE_W / WORD_W,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int BSEL_W = $clog2(WORD_W / 8),
  localparam int PA_W   = PPN_W + PAGE_BITS,
  localparam int TAG_W  = PA_W - OFF_W - IDX_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic [1:0]                 reqWrite,
  input  logic [1:0][VA_W-1:0]       reqVaddr,
  input  logic [1:0][PPN_W-1:0]      reqPpn,
  input  logic [1:0][WORD_W-1:0]     reqWdata,
  input  logic [LINE_W-1:0]          memRdata,
  output logic                       lookupHit,
  output logic                       victimDirty,
  output logic [PA_W-1:0]            memAddr,
  output logic [LINE_W-1:0]          memWdata,
  output logic [1:0]                 rspValid,
  output logic [WORD_W-1:0]          rspData
);

  // arrays
  logic [TAG_W-1:0]  tagMem   [SETS][WAYS];
  logic [WAYS-1:0]   validMem [SETS];
  logic [WAYS-1:0]   dirtyMem [SETS];
  logic [WAYS-2:0]   plruMem  [SETS];
  logic [LINE_W-1:0] dataMem  [SETS*WAYS];

  // pending miss
  logic [IDX_W-1:0]  pSet;
  logic [TAG_W-1:0]  pTag, vTag;
  logic [WSEL_W-1:0] pWord;
  logic              pWrite, pThr;
  logic [WORD_W-1:0] pWdata;
  logic [WAY_W-1:0]  vWay;

  // lookup operands
  logic [IDX_W-1:0]  lkSet;
  logic [TAG_W-1:0]  lkTag;
  logic [WSEL_W-1:0] lkWord;
  logic              lkWrite, lkThr;
  logic [WORD_W-1:0] lkWdata;
  logic [PA_W-1:0]   portPa;
  logic [WAYS-1:0]   hitVec;
  logic [WAY_W-1:0]  hitWay, vicWay;
  logic [LINE_W-1:0] hitLine;
  logic              lookupEn;

  function automatic logic [WAY_W-1:0] plruVictim(input logic [WAYS-2:0] t);
    int node;
    logic [WAY_W-1:0] w;
    node = 0;
    w = '0;
    for (int l = 0; l < WAY_W; l++) begin
      w[WAY_W-1-l] = t[node];
      node = 2 * node + 1 + int'(t[node]);
    end
    return w;
  endfunction

  function automatic logic [WAYS-2:0] plruTouch(input logic [WAYS-2:0] t, input logic [WAY_W-1:0] w);
    int node;
    logic [WAYS-2:0] r;
    node = 0;
    r = t;
    for (int l = 0; l < WAY_W; l++) begin
      r[node] = ~w[WAY_W-1-l];
      node = 2 * node + 1 + int'(w[WAY_W-1-l]);
    end
    return r;
  endfunction

  assign portPa   = {reqPpn[strobe.selThr], reqVaddr[strobe.selThr][PAGE_BITS-1:0]};
  assign lookupEn = strobe.accept || strobe.replay;

  always_comb begin
    if (strobe.replay) begin
      lkSet = pSet; lkTag = pTag; lkWord = pWord;
      lkWrite = pWrite; lkWdata = pWdata; lkThr = pThr;
    end else begin
      lkSet   = reqVaddr[strobe.selThr][OFF_W +: IDX_W];
      lkTag   = portPa[PA_W-1 -: TAG_W];
      lkWord  = reqVaddr[strobe.selThr][BSEL_W +: WSEL_W];
      lkWrite = reqWrite[strobe.selThr];
      lkWdata = reqWdata[strobe.selThr];
      lkThr   = strobe.selThr;
    end
  end

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hitVec[w] = validMem[lkSet][w] && (tagMem[lkSet][w] == lkTag);
    end
  endgenerate

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) hitWay = WAY_W'(w);
    vicWay = plruVictim(plruMem[lkSet]);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!validMem[lkSet][w]) vicWay = WAY_W'(w);
  end

  assign lookupHit   = |hitVec;
  assign victimDirty = validMem[lkSet][vicWay] && dirtyMem[lkSet][vicWay];
  assign hitLine     = dataMem[{lkSet, hitWay}];
  assign memAddr     = strobe.wbPhase ? {vTag, pSet, {OFF_W{1'b0}}} : {pTag, pSet, {OFF_W{1'b0}}};
  assign memWdata    = dataMem[{pSet, vWay}];

  // state with reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= '0;
      rspData  <= '0;
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        dirtyMem[s] <= '0;
        plruMem[s]  <= '0;
      end
    end else begin
      rspValid <= '0;
      if (lookupEn && lookupHit) begin
        rspValid[lkThr] <= 1'b1;
        rspData <= lkWrite ? lkWdata : hitLine[lkWord*WORD_W +: WORD_W];
        plruMem[lkSet] <= plruTouch(plruMem[lkSet], hitWay);
        if (lkWrite) dirtyMem[lkSet][hitWay] <= 1'b1;
      end
      if (strobe.fillEn) begin
        validMem[pSet][vWay] <= 1'b1;
        dirtyMem[pSet][vWay] <= 1'b0;
      end
    end
  end

  // pending capture and storage arrays
  always_ff @(posedge clk) begin
    if (strobe.accept && !lookupHit) begin
      pSet <= lkSet; pTag <= lkTag; pWord <= lkWord;
      pWrite <= lkWrite; pWdata <= lkWdata; pThr <= lkThr;
      vWay <= vicWay;
      vTag <= tagMem[lkSet][vicWay];
    end
    if (lookupEn && lookupHit && lkWrite)
      dataMem[{lkSet, hitWay}][lkWord*WORD_W +: WORD_W] <= lkWdata;
    if (strobe.fillEn) begin
      dataMem[{pSet, vWay}] <= memRdata;
      tagMem[pSet][vWay]    <= pTag;
    end
  end

  logic unusedBits;
  assign unusedBits = ^{reqVaddr[0][VA_W-1:PAGE_BITS], reqVaddr[1][VA_W-1:PAGE_BITS],
                        reqVaddr[0][BSEL_W-1:0], reqVaddr[1][BSEL_W-1:0]};

  // R3
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupEn |-> $onehot0(hitVec));
  // R5
  replay_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.replay |-> lookupHit);
  // R2
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rspValid));
  // R2
  hit_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lookupEn && lookupHit) |=> (rspValid != 2'b00));

endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
  import vipt_dcache_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 64,
  parameter int WAYS       = 8,
  parameter int PPN_W      = 20,
  parameter int PAGE_BITS  = 12,
  parameter int VA_W       = 32,
  parameter int WORD_W     = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [1:0]                       reqValid,
  input  logic [1:0]                       reqWrite,
  input  logic [1:0][VA_W-1:0]             reqVaddr,
  input  logic [1:0][PPN_W-1:0]            reqPpn,
  input  logic [1:0][WORD_W-1:0]           reqWdata,
  output logic [1:0]                       reqGrant,
  output logic [1:0]                       rspValid,
  output logic [WORD_W-1:0]                rspData,
  output logic                             busy,
  output logic                             memReq,
  output logic                             memWe,
  output logic [PPN_W+PAGE_BITS-1:0]       memAddr,
  output logic [LINE_BYTES*8-1:0]          memWdata,
  input  logic [LINE_BYTES*8-1:0]          memRdata,
  input  logic                             memAck
);

  dpStrobe_t strobe;
  logic lookupHit;
  logic victimDirty;

  vipt_dcache_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .lookupHit   (lookupHit),
    .victimDirty (victimDirty),
    .memAck      (memAck),
    .grant       (reqGrant),
    .busy        (busy),
    .memReq      (memReq),
    .memWe       (memWe),
    .strobe      (strobe)
  );

  vipt_dcache_dp #(
    .LINE_BYTES (LINE_BYTES),
    .SETS       (SETS),
    .WAYS       (WAYS),
    .PPN_W      (PPN_W),
    .PAGE_BITS  (PAGE_BITS),
    .VA_W       (VA_W),
    .WORD_W     (WORD_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqWrite    (reqWrite),
    .reqVaddr    (reqVaddr),
    .reqPpn      (reqPpn),
    .reqWdata    (reqWdata),
    .memRdata    (memRdata),
    .lookupHit   (lookupHit),
    .victimDirty (victimDirty),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .rspValid    (rspValid),
    .rspData     (rspData)
  );

  // R11
  memaddr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr));
  // R1
  memaddr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[$clog2(LINE_BYTES)-1:0] == '0));

endmodule

// File: tb/vipt_dcache_tb.sv
module vipt_dcache_tb;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        reqValid = '0;
  logic [1:0]        reqWrite = '0;
  logic [1:0][31:0]  reqVaddr = '0;
  logic [1:0][19:0]  reqPpn = '0;
  logic [1:0][31:0]  reqWdata = '0;
  logic [1:0]        reqGrant, rspValid;
  logic [31:0]       rspData;
  logic              busy, memReq, memWe;
  logic [31:0]       memAddr;
  logic [511:0]      memWdata;
  logic [511:0]      memRdata = '0;
  logic              memAck = 1'b0;

  always #5 clk = ~clk;

  vipt_dcache u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqVaddr(reqVaddr), .reqPpn(reqPpn), .reqWdata(reqWdata),
    .reqGrant(reqGrant), .rspValid(rspValid), .rspData(rspData),
    .busy(busy), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  int checks = 0;
  int errors = 0;

  // reference state
  logic [31:0]  refMem   [logic [31:0]];
  logic [511:0] memStore [logic [31:0]];
  int           wbCount = 0, refillCount = 0;
  logic [31:0]  lastWbAddr = '0, lastRefillAddr = '0;
  logic         lastOpWb = 1'b0, refillAfterWb = 1'b0;

  function automatic logic [31:0] patWord(input logic [31:0] pa);
    return {pa[31:2], 2'b00} ^ 32'h5A00_0000;
  endfunction

  function automatic logic [511:0] patLine(input logic [31:0] la);
    logic [511:0] l;
    for (int k = 0; k < 16; k++) l[k*32 +: 32] = patWord({la[31:6], 4'(k), 2'b00});
    return l;
  endfunction

  function automatic logic [31:0] refRead(input logic [31:0] pa);
    if (refMem.exists(pa)) return refMem[pa];
    return patWord(pa);
  endfunction

  // next-level memory: ack three cycles after a request appears
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(posedge clk);
      if (memAck) begin
        memAck <= 1'b0;
        cnt = 0;
      end else if (memReq) begin
        if (cnt == 2) begin
          memAck <= 1'b1;
          if (memWe) begin
            memStore[memAddr] = memWdata;
            wbCount++;
            lastWbAddr = memAddr;
            lastOpWb = 1'b1;
          end else begin
            memRdata <= memStore.exists(memAddr) ? memStore[memAddr] : patLine(memAddr);
            refillCount++;
            lastRefillAddr = memAddr;
            refillAfterWb = lastOpWb;
            lastOpWb = 1'b0;
          end
        end else cnt++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // one request, called at a negedge; returns at the negedge holding the response
  task automatic doReq(input logic thr, input logic wr, input logic [31:0] va,
                       input logic [19:0] ppn, input logic [31:0] wd,
                       output logic [31:0] data, output logic missSeen, output int lat);
    int waited;
    reqValid[thr] = 1'b1; reqWrite[thr] = wr; reqVaddr[thr] = va;
    reqPpn[thr] = ppn; reqWdata[thr] = wd;
    #1;
    waited = 0;
    while (!reqGrant[thr] && waited < 2000) begin
      @(negedge clk); #1; waited++;
    end
    @(negedge clk);
    reqValid[thr] = 1'b0;
    lat = 1;
    missSeen = busy;
    while (!rspValid[thr] && lat < 2000) begin
      @(negedge clk); lat++;
    end
    data = rspData;
  endtask

  typedef struct packed {
    logic        thr;
    logic        wr;
    logic [31:0] va;
    logic [19:0] ppn;
    logic [31:0] wd;
    logic        expHit;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 32'h0000_1140, 20'h00123, 32'h0, 1'b0},  // cold miss, set 5
    '{1'b0, 1'b0, 32'h0000_1144, 20'h00123, 32'h0, 1'b1},  // other word same line
    '{1'b1, 1'b0, 32'h5555_5140, 20'h00123, 32'h0, 1'b1},  // R3 alias from other thread
    '{1'b1, 1'b1, 32'h5555_5148, 20'h00123, 32'hA5A5_0001, 1'b1},  // R4 write hit via alias
    '{1'b0, 1'b0, 32'h0000_1148, 20'h00123, 32'h0, 1'b1},  // R3 sees alias write
    '{1'b1, 1'b0, 32'h0000_1140, 20'h00456, 32'h0, 1'b0},  // R3 same VA other page misses
    '{1'b0, 1'b0, 32'h0000_1140, 20'h00123, 32'h0, 1'b1},  // both lines share set
    '{1'b0, 1'b1, 32'h0000_2FFC, 20'h00009, 32'hBEEF_0063, 1'b0},  // write miss, set 63 last word
    '{1'b1, 1'b0, 32'h0000_3FFC, 20'h00009, 32'h0, 1'b1},  // R1 index from page offset
    '{1'b0, 1'b0, 32'h0000_003C, 20'h00000, 32'h0, 1'b0}   // set 0
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, pa, expd;
    logic        miss;
    int          lat;
    logic [1:0]  g1, g2;
    logic        winner;
    int          viol;

    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 busy", {31'b0, busy}, 32'h0);
    chk("R10 rspValid", {30'b0, rspValid}, 32'h0);
    chk("R10 memReq", {31'b0, memReq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 grant idle", {30'b0, reqGrant}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      pa = {v.ppn, v.va[11:2], 2'b00};
      doReq(v.thr, v.wr, v.va, v.ppn, v.wd, d, miss, lat);
      if (v.wr) refMem[pa] = v.wd;
      expd = v.wr ? v.wd : refRead(pa);
      if (v.expHit) begin
        chk("R2 hit data", d, expd);
        chk("R2 hit latency", lat, 1);
        chk("R2 hit no busy", {31'b0, miss}, 32'h0);
      end else begin
        chk("R5 miss data", d, expd);
        chk("R5 miss busy", {31'b0, miss}, 32'h1);
      end
      if (i == 7) chk("R5 refill line addr", lastRefillAddr, 32'h0000_9FC0);
    end
    chk("R4 R5 refill count", refillCount, 4);
    chk("R6 clean no writeback", wbCount, 0);

    // R8 arbitration: both threads request hits together
    reqValid = 2'b11; reqWrite = 2'b00;
    reqVaddr[0] = 32'h0000_1140; reqPpn[0] = 20'h00123;
    reqVaddr[1] = 32'h5555_5144; reqPpn[1] = 20'h00123;
    #1;
    g1 = reqGrant;
    chk("R8 one grant", $countones(g1), 1);
    winner = g1[1];
    @(negedge clk);
    chk("R8 winner rsp", {30'b0, rspValid}, winner ? 32'h2 : 32'h1);
    chk("R8 winner data", rspData, refRead(winner ? 32'h0012_3144 : 32'h0012_3140));
    #1;
    g2 = reqGrant;
    chk("R8 loser next", {30'b0, g2}, winner ? 32'h1 : 32'h2);
    @(negedge clk);
    reqValid = 2'b00;
    chk("R8 loser rsp", {30'b0, rspValid}, winner ? 32'h1 : 32'h2);
    chk("R8 loser data", rspData, refRead(winner ? 32'h0012_3140 : 32'h0012_3144));

    // R9 no grants while busy
    @(negedge clk);
    reqValid[0] = 1'b1; reqWrite[0] = 1'b0; reqVaddr[0] = 32'h0000_0500; reqPpn[0] = 20'h00300;
    #1;
    chk("R9 miss granted", {31'b0, reqGrant[0]}, 32'h1);
    @(negedge clk);
    reqValid[0] = 1'b0;
    chk("R5 busy after miss", {31'b0, busy}, 32'h1);
    reqValid[1] = 1'b1; reqWrite[1] = 1'b0; reqVaddr[1] = 32'h0000_1140; reqPpn[1] = 20'h00123;
    viol = 0;
    #1;
    while (busy) begin
      if (reqGrant != 2'b00) viol++;
      @(negedge clk); #1;
    end
    chk("R9 stalled while busy", viol, 0);
    chk("R5 replay rsp", {31'b0, rspValid[0]}, 32'h1);
    chk("R5 replay data", rspData, patWord(32'h0030_0500));
    chk("R9 granted after busy", {31'b0, reqGrant[1]}, 32'h1);
    @(negedge clk);
    reqValid[1] = 1'b0;
    chk("R9 waiting rsp", rspData, refRead(32'h0012_3140));

    // R7 R6: fill set 10 with dirty lines, touch first, ninth miss evicts fifth
    for (int k = 0; k < 8; k++) begin
      doReq(1'b0, 1'b1, 32'h0001_0280, 20'h00100 + 20'(k), 32'hD000_0000 + 32'(k), d, miss, lat);
      refMem[{20'h00100 + 20'(k), 12'h280}] = 32'hD000_0000 + 32'(k);
      chk("R7 fill miss", {31'b0, miss}, 32'h1);
    end
    chk("R7 invalid ways used first", wbCount, 0);
    doReq(1'b1, 1'b0, 32'h0002_0280, 20'h00100, 32'h0, d, miss, lat);
    chk("R7 touch first", d, 32'hD000_0000);
    doReq(1'b0, 1'b0, 32'h0001_0280, 20'h00108, 32'h0, d, miss, lat);
    chk("R6 one writeback", wbCount, 1);
    chk("R7 victim line", lastWbAddr, 32'h0010_4280);
    chk("R6 writeback before refill", {31'b0, refillAfterWb}, 32'h1);
    chk("R6 writeback data", memStore[32'h0010_4280][31:0], 32'hD000_0004);
    chk("R5 ninth line data", d, patWord(32'h0010_8280));
    doReq(1'b1, 1'b0, 32'h0003_0280, 20'h00104, 32'h0, d, miss, lat);
    chk("R6 evicted line returns", d, 32'hD000_0004);
    chk("R6 evicted line missed", {31'b0, miss}, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule